// File: doc/BRIEF.md
# Flash Erase Sequencer

This block runs page, bank and whole-array erase requests for a two-bank flash controller model. Software loads the operation fields (page-erase, bank-erase or whole-array select, page number, bank select, erase length in cycles) and pulses a start strobe. The block validates the request against the bank configuration, the pending error flags and a write-protected page window. It then either raises an error flag or runs the erase for the programmed number of cycles, with busy set for the whole time.

While an erase is in progress, read requests aimed at the bank being erased are stalled. In two-bank mode, reads of the other bank proceed. The clock source needed for erasing is requested automatically for the duration of the operation, or kept on permanently if software has already enabled it. At completion a one-cycle done pulse reports which banks' main arrays were cleared. A whole-array erase reports the main arrays of both banks only.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, busy, start_act, seq_err, wrp_err, done and done_mask are 0, and clk_en is 0 while osc_sw_on is 0.
- R2: An accepted start raises busy on the next clock. Busy stays high for exactly erase_cycles cycles, or for 1 cycle when erase_cycles is 0. In the first cycle with busy low, done is 1 for one cycle and start_act is 0.
- R3: If seq_err or wrp_err is still set after this cycle's clears, a start sets seq_err and no erase begins.
- R4: A start with a number of set operation selects (op_page, op_bank, op_mass) other than exactly one sets seq_err and no erase begins.
- R5: In single-bank mode (dual_bank=0), a start with bank_sel=1 sets seq_err and no erase begins.
- R6: If no sequence error applies, a start whose target is protected sets wrp_err and no erase begins. With wp_en=1, the target is protected in three cases: any op_mass; an op_bank on bank wp_bank; an op_page whose page_num lies in wp_first..wp_last on bank wp_bank. In single-bank mode the bank always matches.
- R7: err_clr bit 0 clears seq_err and bit 1 clears wrp_err (write 1 to clear). A start in the same cycle is judged on the flags after clearing. A flag that the same start sets stays set.
- R8: rd_stall is 1 only while busy, with rd_req=1, and with rd_bank inside the erased region. In two-bank mode, the erased region of a page or bank erase is bank_sel alone. The region is both banks for op_mass or for single-bank mode.
- R9: clk_en is 1 from the clock that launches an erase until the clock that ends it, and otherwise follows osc_sw_on one clock later.
- R10: A start strobe while busy is ignored. No flag changes and the running erase keeps its length.
- R11: With done, done_mask gives the banks whose main array was erased (bit b = bank b): both for op_mass or single-bank mode, otherwise only bank_sel. done_mask is 0 when done is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dual_bank | input | 1 | 1 = two-bank mode, 0 = single-bank mode |
| start_wr | input | 1 | Start strobe, one cycle |
| op_page | input | 1 | Select page erase |
| op_bank | input | 1 | Select bank erase |
| op_mass | input | 1 | Select whole-array erase |
| bank_sel | input | 1 | Target bank |
| page_num | input | PAGE_W | Target page |
| erase_cycles | input | CNT_W | Erase length in cycles (0 acts as 1) |
| err_clr | input | 2 | Write-1-to-clear: bit 0 seq_err, bit 1 wrp_err |
| wp_en | input | 1 | Protection window enable |
| wp_bank | input | 1 | Bank holding the protection window |
| wp_first | input | PAGE_W | First protected page |
| wp_last | input | PAGE_W | Last protected page |
| osc_sw_on | input | 1 | Software has enabled the erase clock source |
| rd_req | input | 1 | Read request |
| rd_bank | input | 1 | Bank of the read |
| busy | output | 1 | Erase in progress |
| start_act | output | 1 | Start bit, self-clearing at the end |
| seq_err | output | 1 | Sequence error flag |
| wrp_err | output | 1 | Write-protection error flag |
| clk_en | output | 1 | Erase clock source request |
| rd_stall | output | 1 | Hold off the current read |
| done | output | 1 | Erase finished pulse |
| done_mask | output | 2 | Banks erased, valid with done |

## Verification
An error-flag clear and a new start request can land in the same cycle. The outcome of that start depends on whether the clear is applied before the stale-flag check. The bench drives err_clr together with start_wr, once with a valid request, which must launch, and once with a faulty request, whose own sequence error must survive the clear. Randomized iterations also mix clears into starts, and a reference function predicts flags and launch from the cleared flag state.

// File: rtl/fer_pkg.sv
package fer_pkg;
  localparam int NBANK = 2;
  typedef enum logic [1:0] {
    V_OK  = 2'd0,
    V_SEQ = 2'd1,
    V_WRP = 2'd2
  } verdict_e;
endpackage

// File: rtl/fer_check.sv
module fer_check
  import fer_pkg::*;
#(
  parameter int PAGE_W = 7
) (
  input  logic              dual_bank,
  input  logic              stale,
  input  logic              op_page,
  input  logic              op_bank,
  input  logic              op_mass,
  input  logic              bank_sel,
  input  logic [PAGE_W-1:0] page_num,
  input  logic              wp_en,
  input  logic              wp_bank,
  input  logic [PAGE_W-1:0] wp_first,
  input  logic [PAGE_W-1:0] wp_last,
  output verdict_e          verdict,
  output logic [NBANK-1:0]  tgt_mask
);
  logic one_op, bank_hit, in_win, prot;

  always_comb begin
    one_op   = ($countones({op_page, op_bank, op_mass}) == 1);
    bank_hit = !dual_bank || (wp_bank == bank_sel);
    in_win   = (page_num >= wp_first) && (page_num <= wp_last);
    prot     = wp_en && (op_mass || (bank_hit && (op_bank || in_win)));
    if (stale || !one_op || (!dual_bank && bank_sel)) verdict = V_SEQ;
    else if (prot)                                     verdict = V_WRP;
    else                                               verdict = V_OK;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_tgt
    assign tgt_mask[b] = op_mass || !dual_bank || (bank_sel == 1'(b));
  end
endmodule

// File: rtl/fer_timer.sv
module fer_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             busy,
  output logic             finish
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (load) begin
      cnt  <= (len == '0) ? CNT_W'(1) : len;
      busy <= 1'b1;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
      if (cnt == CNT_W'(1)) busy <= 1'b0;
    end
  end

  assign finish = busy && (cnt == CNT_W'(1));

  a_r2_cnt_live: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt != '0));
endmodule

// File: rtl/fer_rd_gate.sv
module fer_rd_gate
  import fer_pkg::*;
(
  input  logic             busy,
  input  logic [NBANK-1:0] region,
  input  logic             rd_req,
  input  logic             rd_bank,
  output logic             rd_stall
);
  logic [NBANK-1:0] hit;

  for (genvar b = 0; b < NBANK; b++) begin : g_hit
    assign hit[b] = region[b] && (rd_bank == 1'(b));
  end

  assign rd_stall = rd_req && busy && (|hit);
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import fer_pkg::*;
#(
  parameter int PAGE_W = 7,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dual_bank,
  input  logic              start_wr,
  input  logic              op_page,
  input  logic              op_bank,
  input  logic              op_mass,
  input  logic              bank_sel,
  input  logic [PAGE_W-1:0] page_num,
  input  logic [CNT_W-1:0]  erase_cycles,
  input  logic [1:0]        err_clr,
  input  logic              wp_en,
  input  logic              wp_bank,
  input  logic [PAGE_W-1:0] wp_first,
  input  logic [PAGE_W-1:0] wp_last,
  input  logic              osc_sw_on,
  input  logic              rd_req,
  input  logic              rd_bank,
  output logic              busy,
  output logic              start_act,
  output logic              seq_err,
  output logic              wrp_err,
  output logic              clk_en,
  output logic              rd_stall,
  output logic              done,
  output logic [1:0]        done_mask
);
  logic             seq_kept, wrp_kept, take, launch, finish, start_nx;
  verdict_e         verdict;
  logic [NBANK-1:0] tgt_mask, tgt_q;

  assign seq_kept = seq_err && !err_clr[0];
  assign wrp_kept = wrp_err && !err_clr[1];
  assign take     = start_wr && !busy;
  assign launch   = take && (verdict == V_OK);
  assign start_nx = launch || (start_act && !finish);

  fer_check #(.PAGE_W(PAGE_W)) i_check (
    .dual_bank(dual_bank), .stale(seq_kept || wrp_kept),
    .op_page(op_page), .op_bank(op_bank), .op_mass(op_mass),
    .bank_sel(bank_sel), .page_num(page_num),
    .wp_en(wp_en), .wp_bank(wp_bank), .wp_first(wp_first), .wp_last(wp_last),
    .verdict(verdict), .tgt_mask(tgt_mask)
  );

  fer_timer #(.CNT_W(CNT_W)) i_timer (
    .clk(clk), .rst(rst), .load(launch), .len(erase_cycles),
    .busy(busy), .finish(finish)
  );

  fer_rd_gate i_rd_gate (
    .busy(busy), .region(tgt_q), .rd_req(rd_req), .rd_bank(rd_bank),
    .rd_stall(rd_stall)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_err   <= 1'b0;
      wrp_err   <= 1'b0;
      start_act <= 1'b0;
      clk_en    <= 1'b0;
      tgt_q     <= '0;
      done      <= 1'b0;
      done_mask <= '0;
    end else begin
      seq_err   <= seq_kept || (take && verdict == V_SEQ);
      wrp_err   <= wrp_kept || (take && verdict == V_WRP);
      start_act <= start_nx;
      clk_en    <= osc_sw_on || start_nx;
      if (launch) tgt_q <= tgt_mask;
      done      <= finish;
      done_mask <= finish ? tgt_q : '0;
    end
  end

  a_r3_clean_launch: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (!seq_err && !wrp_err));
  a_r6_wrp_no_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(wrp_err) |-> !busy);
  a_r10_err_only_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(seq_err) |-> !$past(busy));
  a_r8_stall_needs_busy: assert property (@(posedge clk) disable iff (rst)
    rd_stall |-> busy);
  a_r9_clk_with_start: assert property (@(posedge clk) disable iff (rst)
    start_act |-> clk_en);
  a_r2_done_at_fall: assert property (@(posedge clk) disable iff (rst)
    done |-> $fell(busy));
endmodule

// File: tb/test_flash_erase_seq.sv
module test_flash_erase_seq;
  localparam int PAGE_W = 7;
  localparam int CNT_W  = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic dual_bank = 1'b1, start_wr = 1'b0, op_page = 1'b0, op_bank = 1'b0, op_mass = 1'b0;
  logic bank_sel = 1'b0, wp_en = 1'b0, wp_bank = 1'b0, osc_sw_on = 1'b0;
  logic rd_req = 1'b0, rd_bank = 1'b0;
  logic [PAGE_W-1:0] page_num = '0, wp_first = '0, wp_last = '0;
  logic [CNT_W-1:0]  erase_cycles = '0;
  logic [1:0]        err_clr = '0;
  logic busy, start_act, seq_err, wrp_err, clk_en, rd_stall, done;
  logic [1:0] done_mask;

  int checks = 0, errors = 0;
  bit m_seq = 0, m_wrp = 0;

  always #2 clk = ~clk;

  flash_erase_seq #(.PAGE_W(PAGE_W), .CNT_W(CNT_W)) i_flash_erase_seq (
    .clk(clk), .rst(rst), .dual_bank(dual_bank), .start_wr(start_wr),
    .op_page(op_page), .op_bank(op_bank), .op_mass(op_mass), .bank_sel(bank_sel),
    .page_num(page_num), .erase_cycles(erase_cycles), .err_clr(err_clr),
    .wp_en(wp_en), .wp_bank(wp_bank), .wp_first(wp_first), .wp_last(wp_last),
    .osc_sw_on(osc_sw_on), .rd_req(rd_req), .rd_bank(rd_bank),
    .busy(busy), .start_act(start_act), .seq_err(seq_err), .wrp_err(wrp_err),
    .clk_en(clk_en), .rd_stall(rd_stall), .done(done), .done_mask(done_mask)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int verdict_of(bit dual, bit pg, bit bk, bit ms, bit bsel,
                                    int page, bit stale);
    bit hit;
    if (stale) return 1;
    if (int'(pg) + int'(bk) + int'(ms) != 1) return 1;
    if (!dual && bsel) return 1;
    hit = !dual || (wp_bank == bsel);
    if (wp_en && (ms || (hit && (bk || (page >= int'(wp_first) && page <= int'(wp_last))))))
      return 2;
    return 0;
  endfunction

  function automatic bit [1:0] region_of(bit dual, bit ms, bit bsel);
    if (ms || !dual) return 2'b11;
    return bsel ? 2'b10 : 2'b01;
  endfunction

  task automatic run_op(input bit dual, input bit pg, input bit bk, input bit ms,
                        input bit bsel, input int page, input int cyc,
                        input bit [1:0] clr, input bit sw, input bit poke,
                        input string tag);
    int v, n, len;
    bit [1:0] reg_m;
    bit stale;
    @(negedge clk);
    dual_bank = dual; op_page = pg; op_bank = bk; op_mass = ms; bank_sel = bsel;
    page_num = PAGE_W'(page); erase_cycles = CNT_W'(cyc); err_clr = clr;
    osc_sw_on = sw; start_wr = 1'b1;
    stale = (m_seq && !clr[0]) || (m_wrp && !clr[1]);
    v = verdict_of(dual, pg, bk, ms, bsel, page, stale);
    m_seq = (m_seq && !clr[0]) || (v == 1);
    m_wrp = (m_wrp && !clr[1]) || (v == 2);
    @(negedge clk);
    start_wr = 1'b0; err_clr = '0; op_page = 0; op_bank = 0; op_mass = 0;
    check({tag, " R2/R3/R4/R5/R6 busy"}, int'(busy), int'(v == 0));
    check({tag, " R3/R4/R5/R7 seq_err"}, int'(seq_err), int'(m_seq));
    check({tag, " R6/R7 wrp_err"}, int'(wrp_err), int'(m_wrp));
    if (v == 0) begin
      reg_m = region_of(dual, ms, bsel);
      len = (cyc == 0) ? 1 : cyc;
      n = 0;
      while (busy) begin
        n++;
        start_wr = (poke && n == 2);
        if (n == 1) begin
          check({tag, " R9 clk_en while erasing"}, int'(clk_en), 1);
          rd_bank = 1'($urandom % 2); rd_req = 1'b1;
          #1;
          check({tag, " R8 rd_stall"}, int'(rd_stall), int'(reg_m[rd_bank]));
          rd_req = 1'b0;
        end
        @(negedge clk);
      end
      start_wr = 1'b0;
      check({tag, " R2 busy length"}, n, len);
      check({tag, " R2 done"}, int'(done), 1);
      check({tag, " R2 start_act cleared"}, int'(start_act), 0);
      check({tag, " R11 done_mask"}, int'(done_mask), int'(reg_m));
      check({tag, " R9 clk_en after end"}, int'(clk_en), int'(sw));
      if (poke) check({tag, " R10 seq_err unchanged"}, int'(seq_err), int'(m_seq));
      rd_req = 1'b1; rd_bank = 1'b0; #1;
      check({tag, " R8 no stall when idle"}, int'(rd_stall), 0);
      rd_req = 1'b0;
      @(negedge clk);
      check({tag, " R11 done_mask idle"}, int'(done_mask), 0);
    end
  endtask

  task automatic clear_all();
    @(negedge clk); err_clr = 2'b11;
    @(negedge clk); err_clr = 2'b00;
    m_seq = 0; m_wrp = 0;
    check("R7 flags cleared", int'(seq_err) + int'(wrp_err), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy", int'(busy), 0);
    check("R1 flags", int'(seq_err) + int'(wrp_err), 0);
    check("R1 start_act", int'(start_act), 0);
    check("R1 clk_en", int'(clk_en), 0);
    check("R1 done", int'(done) + int'(done_mask), 0);

    run_op(1, 1, 0, 0, 0, 10, 5, 2'b00, 0, 0, "dual page bank0");
    run_op(1, 0, 1, 0, 1, 0, 3, 2'b00, 0, 0, "dual bank1 erase");
    run_op(1, 1, 0, 0, 1, 3, 0, 2'b00, 0, 0, "zero length");
    run_op(0, 1, 0, 0, 1, 3, 4, 2'b00, 0, 0, "R5 single bank_sel");
    run_op(0, 1, 0, 0, 0, 3, 4, 2'b00, 0, 0, "R3 stale flag");
    run_op(0, 1, 0, 0, 0, 3, 4, 2'b01, 0, 0, "R7 clear with start");
    run_op(1, 1, 1, 0, 0, 3, 4, 2'b00, 0, 0, "R4 two ops");
    run_op(1, 0, 0, 0, 0, 3, 4, 2'b01, 0, 0, "R7 set wins over clear");
    clear_all();
    wp_en = 1; wp_bank = 1; wp_first = 7'd20; wp_last = 7'd30;
    run_op(1, 1, 0, 0, 1, 25, 4, 2'b00, 0, 0, "R6 protected page");
    run_op(1, 1, 0, 0, 0, 25, 4, 2'b10, 0, 0, "R6 other bank ok");
    run_op(1, 0, 0, 1, 0, 0, 4, 2'b00, 0, 0, "R6 mass protected");
    clear_all();
    wp_en = 0;
    run_op(1, 1, 0, 0, 0, 5, 6, 2'b00, 0, 1, "R10 start while busy");
    run_op(1, 0, 0, 1, 0, 0, 4, 2'b00, 0, 0, "R11 mass");
    run_op(0, 0, 1, 0, 0, 0, 3, 2'b00, 1, 0, "R9 sw clock on");
    @(negedge clk); osc_sw_on = 0;
    @(negedge clk); @(negedge clk);
    check("R9 clk_en follows sw off", int'(clk_en), 0);

    for (int i = 0; i < 80; i++) begin
      int r, pg_rand;
      bit [1:0] clr;
      r = $urandom % 10;
      wp_en = ($urandom % 3) == 0;
      wp_bank = 1'($urandom % 2);
      wp_first = PAGE_W'($urandom % 64);
      wp_last = wp_first + PAGE_W'($urandom % 64);
      clr = ($urandom % 2) ? 2'b11 : 2'($urandom % 4);
      pg_rand = $urandom % 128;
      run_op(1'($urandom % 2),
             r < 5, r >= 5 && r < 7 || r == 9, r >= 7,
             ($urandom % 3) == 0, pg_rand, $urandom % 12, clr,
             1'($urandom % 2), ($urandom % 4) == 0, "random");
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule